// File: doc/BRIEF.md
# Key Event Queue with Autorepeat

This block sits between a keypad debouncer and the register that a host reads. Each debounced key press or release arrives as a one-cycle write carrying a six-bit key index and a release flag. The block keeps these events in arrival order in a small first-in first-out store. The host takes them out one byte per read strobe. Each byte holds the key index, the event type and a flag that tells whether more bytes remain to be read.

While any key stays held, an autorepeat timer counts debounce periods (one `tick` pulse each). When the programmed number of periods passes with no new key event, the timer writes the repeat code 0x7E into the queue. It then writes the same code again after each further interval, until the keys are released. Key indices 62 and 63 share their codes with the repeat and empty markers. For those two indices the flag bits carry no meaning, and the host has to read once more to learn whether data remains.

Top module: `keyq_top`

## Requirements
- R1: After reset `rd_data` is 0x3F, `overflow` is 0 and the queue is empty.
- R2: In a returned byte, bits [5:0] hold the key index and bit 6 holds the event type: 1 for a release, 0 for a press.
- R3: Events leave the queue in the order they were written. A byte taken by `rd_pop` appears on `rd_data` on the clock edge that samples the strobe, and it holds there until the next pop.
- R4: For key indices 0 to 61, bit 7 is 1 exactly when at least one entry is still queued after the pop. An event written in the same cycle as the pop counts as queued.
- R5: For key indices 62 and 63, bit 7 is always 0 and bit 6 is the stored event type. A repeat marker therefore reads as 0x7E.
- R6: A pop on an empty queue returns 0x3F and changes no state.
- R7: The queue holds 16 entries. A write to a full queue with no pop in the same cycle is dropped, the stored entries are unchanged, and `overflow` goes to 1 and stays there until reset. A write with a pop in the same cycle on a full queue is accepted.
- R8: When `rpt_en` and `held` are both 1, the marker 0x7E is written on the tick that completes `rpt_dly` ticks with no key event. Further markers follow every `rpt_dly` ticks. A delay of 0 behaves as 1.
- R9: A key event restarts the tick count. While `rpt_en` or `held` is 0, the count stays cleared and no marker is written.
- R10: If a key event and a repeat expiry fall in the same cycle, only the key event is written and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Debounced key event strobe |
| ev_key | input | 6 | Key index of the event |
| ev_release | input | 1 | 1 for release, 0 for press |
| tick | input | 1 | One pulse per debounce period |
| held | input | 1 | At least one key is currently held |
| rpt_en | input | 1 | Autorepeat enable |
| rpt_dly | input | 5 | Autorepeat interval in debounce periods |
| rd_pop | input | 1 | Host read strobe, one byte per pulse |
| rd_data | output | 8 | Last byte returned to the host |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
Two operations can land on the same edge. A pop can meet a write, which decides the more-data bit and, on a full queue, whether the write survives. A debouncer event can meet a repeat expiry, and only one of them may take the single write port. The bench provokes the first by raising `rd_pop` and `ev_valid` together, once on a one-entry queue and once on a full one. It then judges the popped byte and the order of the bytes that follow. It provokes the second by pulsing `tick` with an event exactly on the expiry tick. It then checks that only the key event is read back, and that the next marker needs a full fresh interval.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  localparam int KEY_W = 6;
  localparam logic [KEY_W-1:0] RPT_KEY = 6'd62;
  localparam logic [7:0] EMPTY_BYTE = 8'h3F;

  typedef struct packed {
    logic             rel;
    logic [KEY_W-1:0] key;
  } kev_t;

  // Reserved indices 62/63 suppress the more-data bit
  function automatic logic [7:0] fmt_byte(kev_t e, logic more);
    logic reserved;
    reserved = (e.key >= 6'd62);
    fmt_byte = {more & ~reserved, e.rel, e.key};
  endfunction
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         remain,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_N = AW'(DEPTH) == '0 ? (AW+1)'(DEPTH) : (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   n, n_next;
  logic          full, pop_eff, push_ok, drop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    bump = (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (n == '0);
  assign full    = (n == FULL_N);
  assign pop_eff = pop & ~empty;
  assign push_ok = push & (~full | pop_eff);
  assign drop    = push & ~push_ok;
  assign n_next  = n + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_eff};
  assign remain  = (n_next != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      n        <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_eff) rd_ptr <= bump(rd_ptr);
      n <= n_next;
      if (drop) overflow <= 1'b1;
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n <= FULL_N);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (n == FULL_N && overflow));
  // R6
  empty_pop_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/keyq_repeat.sv
module keyq_repeat #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ev_seen,
  input  logic             held,
  input  logic             en,
  input  logic [DLY_W-1:0] dly,
  output logic             rpt_push
);
  logic [DLY_W-1:0] cnt;
  logic             armed;

  // Expiry test: ticks counted so far plus this one reach the delay (0 acts as 1)
  function automatic logic expired(logic [DLY_W-1:0] c, logic [DLY_W-1:0] d);
    logic [DLY_W:0] eff;
    eff = (d == '0) ? (DLY_W+1)'(1) : {1'b0, d};
    expired = ({1'b0, c} + 1'b1) >= eff;
  endfunction

  assign armed    = en & held & ~ev_seen;
  assign rpt_push = armed & tick & expired(cnt, dly);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (!armed)    cnt <= '0;
    else if (rpt_push)  cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end

  // R9
  idle_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !held) |-> !rpt_push);
  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seen |=> (cnt == '0));
  // R8
  repeat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_push |=> (cnt == '0));
endmodule

// File: rtl/keyq_top.sv
module keyq_top
  import keyq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [5:0]       ev_key,
  input  logic             ev_release,
  input  logic             tick,
  input  logic             held,
  input  logic             rpt_en,
  input  logic [DLY_W-1:0] rpt_dly,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             overflow
);
  localparam int EW = $bits(kev_t);

  logic   rpt_push, wr_en, q_empty, q_remain;
  kev_t   wr_ev, hd_ev;
  logic [EW-1:0] hd_raw;

  keyq_repeat #(.DLY_W(DLY_W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_seen(ev_valid),
    .held(held), .en(rpt_en), .dly(rpt_dly), .rpt_push(rpt_push)
  );

  assign wr_en = ev_valid | rpt_push;
  always_comb begin
    if (ev_valid) wr_ev = '{rel: ev_release, key: ev_key};
    else          wr_ev = '{rel: 1'b1, key: RPT_KEY};
  end

  keyq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_ev),
    .pop(rd_pop), .head(hd_raw), .empty(q_empty),
    .remain(q_remain), .overflow(overflow)
  );
  assign hd_ev = kev_t'(hd_raw);

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= EMPTY_BYTE;
    else if (rd_pop) rd_data <= q_empty ? EMPTY_BYTE : fmt_byte(hd_ev, q_remain);
  end

  // R5
  reserved_no_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:1] == 5'b11111) |-> !rd_data[7]);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && q_empty) |=> (rd_data == EMPTY_BYTE));
  // R3
  hold_between_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pop |=> $stable(rd_data));
endmodule

// File: tb/tb_keyq_top.sv
`timescale 1ns/1ps
module tb_keyq_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, ev_release = 0, tick = 0, held = 0, rpt_en = 0, rd_pop = 0;
  logic [5:0] ev_key = '0;
  logic [4:0] rpt_dly = '0;
  logic [7:0] rd_data;
  logic overflow;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  keyq_top dut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_key(ev_key),
    .ev_release(ev_release), .tick(tick), .held(held), .rpt_en(rpt_en),
    .rpt_dly(rpt_dly), .rd_pop(rd_pop), .rd_data(rd_data), .overflow(overflow));

  function automatic logic [7:0] exp_byte(int key, int rel, int left);
    logic more;
    more = (left > 0) && (key < 62);
    exp_byte = {more, rel[0], key[5:0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ev_valid = 0; tick = 0; rd_pop = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic put(int key, int rel, bit with_tick = 0, bit with_pop = 0);
    ev_valid = 1; ev_key = key[5:0]; ev_release = rel[0]; tick = with_tick; rd_pop = with_pop;
    @(negedge clk); ev_valid = 0; tick = 0; rd_pop = 0;
  endtask

  task automatic pulse_ticks(int k);
    for (int i = 0; i < k; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  task automatic take(string req, logic [7:0] exp);
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk(req, rd_data, exp);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", rd_data, 8'h3F);
    chk("R1", {7'd0, overflow}, 8'd0);
    take("R1", 8'h3F);

    // R2 R5 exhaustive key/type encoding, single entry
    for (int k = 0; k < 64; k++)
      for (int r = 0; r < 2; r++) begin
        put(k, r);
        take("R2_R5", exp_byte(k, r, 0));
      end

    // R4 R5 more-data bit with two queued
    for (int k = 0; k < 64; k += 7) begin
      put(k, k & 1); put(63 - k, 0);
      take("R4", exp_byte(k, k & 1, 1));
      take("R4", exp_byte(63 - k, 0, 0));
    end
    put(62, 0); put(1, 0);
    take("R5", exp_byte(62, 0, 1));
    take("R5", exp_byte(1, 0, 0));

    // R6 empty pops
    take("R6", 8'h3F); take("R6", 8'h3F);
    chk("R6", {7'd0, overflow}, 8'd0);

    // R4 same-cycle write and pop on one-entry queue
    put(10, 0);
    put(11, 1, 0, 1);
    chk("R4", rd_data, exp_byte(10, 0, 1));
    take("R4", exp_byte(11, 1, 0));
    take("R6", 8'h3F);

    // R3 R7 fill past depth: 17th dropped
    for (int i = 0; i < 17; i++) put(i, i % 2);
    chk("R7", {7'd0, overflow}, 8'd1);
    for (int i = 0; i < 16; i++) take("R3_R7", exp_byte(i, i % 2, 15 - i));
    take("R7", 8'h3F);
    chk("R7", {7'd0, overflow}, 8'd1);

    // R7 full queue with simultaneous pop accepts the write
    do_reset();
    for (int i = 0; i < 16; i++) put(20 + i, 0);
    put(50, 1, 0, 1);
    chk("R7", rd_data, exp_byte(20, 0, 1));
    for (int i = 1; i < 16; i++) take("R7", exp_byte(20 + i, 0, 16 - i));
    take("R7", exp_byte(50, 1, 0));
    chk("R7", {7'd0, overflow}, 8'd0);

    // R8 repeat interval sweep
    rpt_en = 1; held = 1;
    for (int d = 0; d < 7; d++) begin
      int eff;
      eff = (d == 0) ? 1 : d;
      rpt_dly = d[4:0];
      put(5, 0);
      pulse_ticks(eff - 1);
      take("R8", exp_byte(5, 0, 0));
      pulse_ticks(1);
      take("R8", 8'h7E);
      pulse_ticks(eff - 1);
      take("R8", 8'h3F);
      pulse_ticks(1);
      take("R8", 8'h7E);
      take("R8", 8'h3F);
    end

    // R9 disabled or released: no markers
    rpt_dly = 2; rpt_en = 0; put(7, 0); pulse_ticks(40);
    take("R9", exp_byte(7, 0, 0)); take("R9", 8'h3F);
    rpt_en = 1; held = 0; put(8, 1); pulse_ticks(40);
    take("R9", exp_byte(8, 1, 0)); take("R9", 8'h3F);
    // R9 key event restarts the count
    held = 1; rpt_dly = 3; put(9, 0); pulse_ticks(2); put(9, 1); pulse_ticks(2);
    take("R9", exp_byte(9, 0, 1)); take("R9", exp_byte(9, 1, 0)); take("R9", 8'h3F);
    pulse_ticks(1); take("R9", 8'h7E);

    // R10 event and expiry together
    rpt_dly = 2; put(30, 0); pulse_ticks(1);
    put(31, 0, 1);
    take("R10", exp_byte(30, 0, 1)); take("R10", exp_byte(31, 0, 0));
    pulse_ticks(1); take("R10", 8'h3F);
    pulse_ticks(1); take("R10", 8'h7E);
    held = 0; rpt_en = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule